// File: doc/BRIEF.md
# Banked CPU Register File

This block is the register file of a classic 8-bit processor whose registers pair up into 16-bit words. It keeps the accumulator/flags pair, the three general pairs, two index pairs, the stack pointer, the program counter, the interrupt/refresh pair and a hidden temporary pair. The accumulator/flags pair and the three general pairs also exist as an alternate set. An exchange is not done by moving data. One toggle bit picks which physical set is active, and a second toggle bit swaps the roles of the two index pairs.

Several ports can act in the same cycle. A byte port reads and writes single high or low halves. A 16-bit port reads and writes whole pairs. A copy path moves one pair into another in a single cycle with no staging latch. An address port shows one pair toward the address path and can step that pair up or down by one, alongside any register access. The program counter is reached through the address port, so an opcode-fetch increment can overlap with a result write on the byte port.

Top module: `cpu_regfile`

## Requirements
- R1: An active-low asynchronous reset clears both toggle bits, so the main set and the unswapped index pairs are active. The stored register values are left as they were.
- R2: The byte port uses these 4-bit codes: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=F (low of AF), 7=A (high of AF), 8/9=IX high/low, 10/11=IY high/low, 12/13=temporary high/low, 14/15=SP high/low. Reads are combinational. A write lands on the next rising edge.
- R3: Pulsing the set toggle for one cycle exchanges the active BC, DE, HL and AF with their alternates. Pulsing it again brings the first set back.
- R4: Pulsing the index toggle exchanges what the IX and IY codes reach.
- R5: Pair codes are 0=BC, 1=DE, 2=HL, 3=AF, 4=IX, 5=IY, 6=temporary, 7=SP, 8=PC, 9=IR. The pair port and the byte port see the same storage.
- R6: A copy writes the source pair's value into the destination pair at the next edge. The source is left unchanged.
- R7: The address output shows the selected pair. A step adds one, or subtracts one when stepping down, wrapping modulo 2^16, in the same cycle as an unrelated byte or pair access.
- R8: When several writes reach one pair in the same cycle, the priority from highest to lowest is pair write, copy, step, byte write. Reads in that cycle return the old value.
- R9: A toggle takes effect at the next edge. Every access in the same cycle as the toggle uses the old mapping.
- R10: Pair codes 10 to 15 read as zero. Writes, copies and steps that use them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the toggle bits |
| brd_sel | input | 4 | Byte read code |
| brd_data | output | 8 | Byte read data |
| bwr_en | input | 1 | Byte write enable |
| bwr_sel | input | 4 | Byte write code |
| bwr_data | input | 8 | Byte write data |
| prd_sel | input | 4 | Pair read code |
| prd_data | output | 16 | Pair read data |
| pwr_en | input | 1 | Pair write enable |
| pwr_sel | input | 4 | Pair write code |
| pwr_data | input | 16 | Pair write data |
| cp_en | input | 1 | Pair copy enable |
| cp_src | input | 4 | Copy source pair code |
| cp_dst | input | 4 | Copy destination pair code |
| adr_sel | input | 4 | Pair code driven to the address output and stepped |
| adr_out | output | 16 | Selected pair toward the address path |
| step_en | input | 1 | Step the address pair at the next edge |
| step_down | input | 1 | Step direction, 1 = subtract one |
| flip_set | input | 1 | Toggle main/alternate set selection |
| flip_idx | input | 1 | Toggle IX/IY role swap |

## Verification
All three read outputs are combinational. Each one is therefore compared in the same cycle its selects are driven, 1 ns after the falling edge, while that cycle's writes and toggles are still pending. This is how the old-value rule is confirmed. Writes, copies, steps and toggles become visible exactly one rising edge later. The bench reference model is updated just after that edge from the inputs that were held across it, and the next cycle's compare sees the result. Reset acts without a clock edge, so its effect on the mapping is checked in the first cycle after release.

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      brd_sel,
  output logic [BW-1:0]   brd_data,
  input  logic            bwr_en,
  input  logic [3:0]      bwr_sel,
  input  logic [BW-1:0]   bwr_data,
  input  logic [3:0]      prd_sel,
  output logic [2*BW-1:0] prd_data,
  input  logic            pwr_en,
  input  logic [3:0]      pwr_sel,
  input  logic [2*BW-1:0] pwr_data,
  input  logic            cp_en,
  input  logic [3:0]      cp_src,
  input  logic [3:0]      cp_dst,
  input  logic [3:0]      adr_sel,
  output logic [2*BW-1:0] adr_out,
  input  logic            step_en,
  input  logic            step_down,
  input  logic            flip_set,
  input  logic            flip_idx
);
  localparam int PW   = 2 * BW;
  localparam int NPHY = 14;
  typedef logic [$clog2(NPHY+1)-1:0] idx_t;
  localparam idx_t NONE = idx_t'(NPHY);

  logic [PW-1:0] rf  [NPHY];
  logic [PW-1:0] nxt [NPHY];
  logic set_q, idx_q;

  function automatic idx_t phys(input logic [3:0] c, input logic s, input logic x);
    case (c)
      4'd0, 4'd1, 4'd2, 4'd3: phys = idx_t'({s, c[1:0]});
      4'd4:    phys = x ? idx_t'(9) : idx_t'(8);
      4'd5:    phys = x ? idx_t'(8) : idx_t'(9);
      4'd6:    phys = idx_t'(11);
      4'd7:    phys = idx_t'(10);
      4'd8:    phys = idx_t'(12);
      4'd9:    phys = idx_t'(13);
      default: phys = NONE;
    endcase
  endfunction

  function automatic logic [PW-1:0] rd(input idx_t i);
    return (i < NONE) ? rf[i] : '0;
  endfunction

  function automatic logic hi_half(input logic [3:0] c);
    return (c[3:1] == 3'd3) ? c[0] : ~c[0];
  endfunction

  idx_t br_i, bw_i, pr_i, pw_i, cs_i, cd_i, st_i;
  logic [PW-1:0] br_w, cp_val, step_val;

  assign br_i = phys({1'b0, brd_sel[3:1]}, set_q, idx_q);
  assign bw_i = phys({1'b0, bwr_sel[3:1]}, set_q, idx_q);
  assign pr_i = phys(prd_sel, set_q, idx_q);
  assign pw_i = phys(pwr_sel, set_q, idx_q);
  assign cs_i = phys(cp_src, set_q, idx_q);
  assign cd_i = phys(cp_dst, set_q, idx_q);
  assign st_i = phys(adr_sel, set_q, idx_q);

  assign br_w     = rd(br_i);
  assign brd_data = hi_half(brd_sel) ? br_w[PW-1:BW] : br_w[BW-1:0];
  assign prd_data = rd(pr_i);
  assign adr_out  = rd(st_i);
  assign cp_val   = rd(cs_i);
  assign step_val = step_down ? adr_out - 1'b1 : adr_out + 1'b1;

  always_comb begin
    for (int i = 0; i < NPHY; i++) begin
      nxt[i] = rf[i];
      if (bwr_en && bw_i == idx_t'(i)) begin
        if (hi_half(bwr_sel)) nxt[i][PW-1:BW] = bwr_data;
        else                  nxt[i][BW-1:0]  = bwr_data;
      end
      if (step_en && st_i == idx_t'(i)) nxt[i] = step_val;
      if (cp_en && cs_i != NONE && cd_i == idx_t'(i)) nxt[i] = cp_val;
      if (pwr_en && pw_i == idx_t'(i)) nxt[i] = pwr_data;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPHY; i++) rf[i] <= nxt[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= 1'b0;
      idx_q <= 1'b0;
    end else begin
      set_q <= set_q ^ flip_set;
      idx_q <= idx_q ^ flip_idx;
    end
  end

  p_set_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flip_set |=> set_q != $past(set_q));
  p_set_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !flip_set |=> $stable(set_q));
  p_idx_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flip_idx |=> idx_q != $past(idx_q));
  p_pair_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && pw_i != NONE) |=> rf[$past(pw_i)] == $past(pwr_data));
  p_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_en && cs_i != NONE && cd_i != NONE && !(pwr_en && pw_i == cd_i))
    |=> rf[$past(cd_i)] == $past(cp_val));
  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && st_i != NONE && !(pwr_en && pw_i == st_i) &&
     !(cp_en && cs_i != NONE && cd_i == st_i))
    |=> rf[$past(st_i)] == $past(step_val));
endmodule

// File: tb/cpu_regfile_tb.sv
module cpu_regfile_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] brd_sel = '0, bwr_sel = '0, prd_sel = '0, pwr_sel = '0;
  logic [3:0] cp_src = '0, cp_dst = '0, adr_sel = '0;
  logic [7:0] brd_data, bwr_data = '0;
  logic [15:0] prd_data, pwr_data = '0, adr_out;
  logic bwr_en = 0, pwr_en = 0, cp_en = 0, step_en = 0, step_down = 0;
  logic flip_set = 0, flip_idx = 0;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [15:0] mv [10];
  logic [15:0] alt [4];
  bit mts = 0, mti = 0;

  always #(CLK_P/2) clk = ~clk;

  cpu_regfile u_dut (.*);

  function automatic logic [15:0] exp_pair(input logic [3:0] c);
    return (c < 4'd10) ? mv[c] : 16'h0;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [3:0] c);
    logic [15:0] v = mv[c[3:1]];
    logic hi = (c[3:1] == 3'd3) ? c[0] : !c[0];
    return hi ? v[15:8] : v[7:0];
  endfunction

  task automatic swap_sets();
    for (int k = 0; k < 4; k++) begin
      logic [15:0] t = mv[k];
      mv[k] = alt[k];
      alt[k] = t;
    end
  endtask

  task automatic swap_idx();
    logic [15:0] t = mv[4];
    mv[4] = mv[5];
    mv[5] = t;
  endtask

  task automatic model_update();
    logic [15:0] o [10];
    logic [15:0] n [10];
    for (int k = 0; k < 10; k++) begin o[k] = mv[k]; n[k] = mv[k]; end
    if (bwr_en) begin
      int p = bwr_sel[3:1];
      bit hi = (p == 3) ? bwr_sel[0] : !bwr_sel[0];
      if (hi) n[p][15:8] = bwr_data; else n[p][7:0] = bwr_data;
    end
    if (step_en && adr_sel < 10) n[adr_sel] = step_down ? o[adr_sel] - 16'd1 : o[adr_sel] + 16'd1;
    if (cp_en && cp_src < 10 && cp_dst < 10) n[cp_dst] = o[cp_src];
    if (pwr_en && pwr_sel < 10) n[pwr_sel] = pwr_data;
    for (int k = 0; k < 10; k++) mv[k] = n[k];
    if (flip_set) begin swap_sets(); mts = !mts; end
    if (flip_idx) begin swap_idx(); mti = !mti; end
  endtask

  task automatic cmp16(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check(input string tag);
    #1;
    cmp16(tag, "byte", {8'h0, brd_data}, {8'h0, exp_byte(brd_sel)});
    cmp16(tag, "pair", prd_data, exp_pair(prd_sel));
    cmp16(tag, "addr", adr_out, exp_pair(adr_sel));
  endtask

  task automatic quiet();
    bwr_en = 0; pwr_en = 0; cp_en = 0; step_en = 0; flip_set = 0; flip_idx = 0;
  endtask

  task automatic cycle(input string tag);
    check(tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic look(input string tag, input logic [3:0] p, input logic [3:0] b, input logic [3:0] a);
    quiet(); prd_sel = p; brd_sel = b; adr_sel = a;
    cycle(tag);
  endtask

  task automatic wr_pair(input logic [3:0] c, input logic [15:0] d);
    quiet(); pwr_en = 1; pwr_sel = c; pwr_data = d;
    cycle("R5");
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 10; k++) begin
      logic [15:0] d = 16'h1111 * 16'(k + 1);
      mv[k] = d;
      quiet(); pwr_en = 1; pwr_sel = 4'(k); pwr_data = d;
      @(posedge clk); @(negedge clk);
    end
    quiet(); flip_set = 1; @(posedge clk); @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      logic [15:0] d = 16'hA0A0 + 16'(k);
      alt[k] = d;
      quiet(); pwr_en = 1; pwr_sel = 4'(k); pwr_data = d;
      @(posedge clk); @(negedge clk);
    end
    quiet(); flip_set = 1; @(posedge clk); @(negedge clk);

    // R5 pair reads and R2 byte codes including F/A order
    for (int k = 0; k < 16; k++) look("R5", 4'(k), 4'(k), 4'((k + 3) % 16));
    quiet(); bwr_en = 1; bwr_sel = 4'd7; bwr_data = 8'h5A; cycle("R2");
    look("R2", 4'd3, 4'd6, 4'd3);
    quiet(); bwr_en = 1; bwr_sel = 4'd13; bwr_data = 8'hC3; cycle("R2");
    look("R2", 4'd6, 4'd12, 4'd6);
    // R3 set toggle
    quiet(); flip_set = 1; prd_sel = 4'd0; cycle("R3");
    look("R3", 4'd0, 4'd7, 4'd2);
    quiet(); flip_set = 1; cycle("R3");
    look("R3", 4'd1, 4'd2, 4'd3);
    // R4 index toggle
    quiet(); flip_idx = 1; cycle("R4");
    look("R4", 4'd4, 4'd10, 4'd5);
    // R9 write in toggle cycle uses old mapping
    quiet(); flip_set = 1; pwr_en = 1; pwr_sel = 4'd0; pwr_data = 16'hBEEF; prd_sel = 4'd0; cycle("R9");
    look("R9", 4'd0, 4'd0, 4'd0);
    quiet(); flip_set = 1; cycle("R9");
    look("R9", 4'd0, 4'd1, 4'd0);
    // R6 copy HL -> BC
    quiet(); cp_en = 1; cp_src = 4'd2; cp_dst = 4'd0; prd_sel = 4'd0; cycle("R6");
    look("R6", 4'd0, 4'd5, 4'd2);
    // R7 wrap and overlap with byte write
    wr_pair(4'd7, 16'hFFFF);
    quiet(); step_en = 1; adr_sel = 4'd7; bwr_en = 1; bwr_sel = 4'd3; bwr_data = 8'h77; cycle("R7");
    look("R7", 4'd7, 4'd3, 4'd7);
    quiet(); step_en = 1; step_down = 1; adr_sel = 4'd8; cycle("R7");
    quiet(); step_en = 1; step_down = 1; adr_sel = 4'd7; cycle("R7");
    look("R7", 4'd8, 4'd14, 4'd7);
    // R8 all writers on HL
    quiet(); pwr_en = 1; pwr_sel = 4'd2; pwr_data = 16'h1234; cp_en = 1; cp_src = 4'd0; cp_dst = 4'd2;
    step_en = 1; adr_sel = 4'd2; bwr_en = 1; bwr_sel = 4'd4; bwr_data = 8'hAA; prd_sel = 4'd2; cycle("R8");
    look("R8", 4'd2, 4'd4, 4'd2);
    quiet(); cp_en = 1; cp_src = 4'd0; cp_dst = 4'd2; step_en = 1; adr_sel = 4'd2; prd_sel = 4'd2; cycle("R8");
    look("R8", 4'd2, 4'd5, 4'd2);
    // R10 invalid codes
    quiet(); pwr_en = 1; pwr_sel = 4'd12; pwr_data = 16'hDEAD; cp_en = 1; cp_src = 4'd11; cp_dst = 4'd1;
    step_en = 1; adr_sel = 4'd15; cycle("R10");
    look("R10", 4'd12, 4'd2, 4'd15);
    look("R10", 4'd1, 4'd3, 4'd10);
    // R1 reset with both toggles set
    quiet(); flip_set = 1; flip_idx = 1; cycle("R1");
    rst_n = 0;
    #2;
    if (mts) swap_sets();
    if (mti) swap_idx();
    mts = 0; mti = 0;
    @(negedge clk); rst_n = 1;
    for (int k = 0; k < 10; k++) look("R1", 4'(k), 4'(k), 4'(9 - k));

    // random mix
    for (int n = 0; n < 3000; n++) begin
      bwr_en = ($urandom % 3) == 0; bwr_sel = 4'($urandom); bwr_data = 8'($urandom);
      pwr_en = ($urandom % 4) == 0; pwr_sel = 4'($urandom % 12); pwr_data = 16'($urandom);
      cp_en = ($urandom % 4) == 0; cp_src = 4'($urandom % 12); cp_dst = 4'($urandom % 12);
      step_en = ($urandom % 3) == 0; step_down = 1'($urandom); adr_sel = 4'($urandom % 12);
      flip_set = ($urandom % 8) == 0; flip_idx = ($urandom % 8) == 0;
      prd_sel = 4'($urandom % 12); brd_sel = 4'($urandom);
      cycle("R8");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule